// File: doc/BRIEF.md
# Signed Byte Acquire Load Unit

This unit executes a single signed-byte load instruction with acquire ordering. It accepts one 32-bit instruction word, checks the fixed opcode bits, pulls out the destination index, the base index and a 9-bit signed byte offset, and forms the address. The base is either a general register, supplied by the surrounding register file through a lookup port, or the stack pointer. It then issues a one-byte read over a valid/ready request channel. When the response arrives, it sign-extends the byte to 32 or 64 bits and presents it on a writeback port.

While the load is being executed, the unit raises a stall output. The pipeline uses it to hold every younger memory read until this load has written back, which is how acquire ordering is enforced. Words that are not this instruction, a disabled feature, and a misaligned stack pointer each end the instruction with a one-cycle flag. None of these cases issues a memory request.

Top module: `sbl_top`

## Requirements
- R1: An accepted word is this instruction only when bits[31:24]=0x19, bit[21]=0, bits[11:10]=00 and opc=bits[23:22] is 10 or 11. Any other word gives a one-cycle `notThisInst` pulse in the cycle after acceptance and no memory request.
- R2: A matching word accepted while `featEnable` is 0 gives a one-cycle `undefInst` pulse and no memory request. This check takes priority over the alignment fault.
- R3: The request address is the base value plus imm9=bits[20:12], sign-extended and not scaled. The offset range is -256 to +255.
- R4: `baseIdx` shows Rn=bits[9:5]. If Rn is 31, the base is `spVal` and `memReqTagChk` is 0. Otherwise the base is `baseVal` and `memReqTagChk` is 1.
- R5: If Rn is 31, `spAlignCheck` is 1 and `spVal` bits[3:0] are not zero, the unit gives a one-cycle `spAlignFault` pulse. There is no request and no writeback.
- R6: The request appears in the cycle after acceptance. It stays valid with a stable address and tag flag until `memReqReady` is seen.
- R7: opc=10 writes the byte sign-extended to 64 bits, to `wbIdx` = Rt = bits[4:0].
- R8: opc=11 writes the byte sign-extended to 32 bits in `wbData` bits[31:0], with bits[63:32] zero.
- R9: `inFlight` is high from the cycle after request acceptance through the writeback cycle. `loadStall` is high and `instReady` is low from the cycle after instruction acceptance through writeback.
- R10: `wbValid` is high for exactly the one cycle after the response handshake, whatever the byte value.
- R11: After reset, `instReady` is 1 and every valid, flag, `inFlight` and `loadStall` output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| featEnable | input | 1 | Instruction feature enabled |
| spAlignCheck | input | 1 | Stack-pointer alignment checking enabled |
| instValid | input | 1 | Instruction word offered |
| instReady | output | 1 | Unit idle and able to accept |
| instWord | input | 32 | Instruction word |
| baseIdx | output | 5 | Base register index for the register file lookup |
| baseVal | input | 64 | Value of the general register at `baseIdx` |
| spVal | input | 64 | Current stack pointer |
| memReqValid | output | 1 | Byte read request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 64 | Byte address |
| memReqTagChk | output | 1 | Access is tag-checked |
| memRspValid | input | 1 | Read data valid |
| memRspReady | output | 1 | Unit waiting for read data |
| memRspData | input | 8 | Returned byte |
| wbValid | output | 1 | Writeback strobe |
| wbIdx | output | 5 | Destination register index |
| wbData | output | 64 | Value written to the destination register |
| inFlight | output | 1 | Request accepted and not yet written back |
| loadStall | output | 1 | Hold younger memory reads |
| notThisInst | output | 1 | Word is not this instruction |
| undefInst | output | 1 | Feature disabled, instruction undefined |
| spAlignFault | output | 1 | Stack-pointer alignment fault |

## Verification
Loads are run with bytes whose top bit is set and with bytes whose top bit is clear. Each is run in both result widths, so a wrong fill source and a missing upper-half clear show up separately. The offset is driven at +5, -16, -256 and +255 to catch an unsigned or truncated offset. The stack-pointer base is run aligned, misaligned with checking enabled and misaligned with checking disabled, which separates the base selection from the fault gating. Words with single wrong fixed bits, an out-of-range opc and a disabled feature confirm that no request leaves the unit, and that the undefined flag wins over the alignment fault.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
  localparam int XLEN      = 64;
  localparam int HALF_W    = XLEN / 2;
  localparam int IMM_W     = 9;
  localparam int IDX_W     = 5;
  localparam int BYTE_W    = 8;
  localparam logic [IDX_W-1:0] SP_IDX = '1;
  localparam logic [7:0] OPC_HI_FIXED = 8'h19;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_WB} sbl_state_e;

  typedef struct packed {
    logic latchInst;
    logic latchRsp;
  } sbl_strobe_t;

  typedef struct packed {
    logic isMatch;
    logic spFault;
  } sbl_decode_t;
endpackage

// File: rtl/sbl_datapath.sv
module sbl_datapath
  import sbl_pkg::*;
#(
  parameter int SP_ALIGN_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbl_strobe_t       strobe,
  input  logic [31:0]       instWord,
  input  logic [XLEN-1:0]   baseVal,
  input  logic [XLEN-1:0]   spVal,
  input  logic              spAlignCheck,
  input  logic [BYTE_W-1:0] memRspData,
  output sbl_decode_t       dec,
  output logic [IDX_W-1:0]  baseIdx,
  output logic [XLEN-1:0]   memReqAddr,
  output logic              memReqTagChk,
  output logic [IDX_W-1:0]  wbIdx,
  output logic [XLEN-1:0]   wbData
);
  logic [IDX_W-1:0]  rnField;
  logic [XLEN-1:0]   offsetExt;
  logic [XLEN-1:0]   baseSel;
  logic              useSp;
  logic              fixedOk;
  logic              opcOk;
  logic [XLEN-1:0]   addrQ;
  logic              tagQ;
  logic [IDX_W-1:0]  rtQ;
  logic              narrowQ;
  logic [BYTE_W-1:0] byteQ;

  assign rnField   = instWord[9:5];
  assign baseIdx   = rnField;
  assign useSp     = (rnField == SP_IDX);
  assign offsetExt = {{(XLEN-IMM_W){instWord[20]}}, instWord[20:12]};
  assign baseSel   = useSp ? spVal : baseVal;

  assign fixedOk = (instWord[31:24] == OPC_HI_FIXED) && !instWord[21]
                   && (instWord[11:10] == 2'b00);
  assign opcOk   = instWord[23];

  assign dec.isMatch = fixedOk && opcOk;
  assign dec.spFault = useSp && spAlignCheck && (spVal[SP_ALIGN_LOG2-1:0] != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      tagQ    <= 1'b0;
      rtQ     <= '0;
      narrowQ <= 1'b0;
    end else if (strobe.latchInst) begin
      addrQ   <= baseSel + offsetExt;
      tagQ    <= !useSp;
      rtQ     <= instWord[4:0];
      narrowQ <= instWord[22];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                byteQ <= '0;
    else if (strobe.latchRsp) byteQ <= memRspData;
  end

  assign memReqAddr   = addrQ;
  assign memReqTagChk = tagQ;
  assign wbIdx        = rtQ;

  always_comb begin
    if (narrowQ)
      wbData = {{HALF_W{1'b0}}, {(HALF_W-BYTE_W){byteQ[BYTE_W-1]}}, byteQ};
    else
      wbData = {{(XLEN-BYTE_W){byteQ[BYTE_W-1]}}, byteQ};
  end
endmodule

// File: rtl/sbl_ctrl.sv
module sbl_ctrl
  import sbl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instValid,
  input  logic        featEnable,
  input  sbl_decode_t dec,
  input  logic        memReqReady,
  input  logic        memRspValid,
  output sbl_strobe_t strobe,
  output logic        instReady,
  output logic        memReqValid,
  output logic        memRspReady,
  output logic        wbValid,
  output logic        inFlight,
  output logic        loadStall,
  output logic        notThisInst,
  output logic        undefInst,
  output logic        spAlignFault
);
  sbl_state_e state, stateNext;
  logic accept, goNt, goUd, goFault, goLoad;

  assign instReady = (state == ST_IDLE);
  assign accept    = instValid && instReady;
  assign goNt      = accept && !dec.isMatch;
  assign goUd      = accept && dec.isMatch && !featEnable;
  assign goFault   = accept && dec.isMatch && featEnable && dec.spFault;
  assign goLoad    = accept && dec.isMatch && featEnable && !dec.spFault;

  assign strobe.latchInst = goLoad;
  assign strobe.latchRsp  = (state == ST_WAIT) && memRspValid;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (goLoad) stateNext = ST_REQ;
      ST_REQ:  if (memReqReady) stateNext = ST_WAIT;
      ST_WAIT: if (memRspValid) stateNext = ST_WB;
      ST_WB:   stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      notThisInst  <= 1'b0;
      undefInst    <= 1'b0;
      spAlignFault <= 1'b0;
    end else begin
      state        <= stateNext;
      notThisInst  <= goNt;
      undefInst    <= goUd;
      spAlignFault <= goFault;
    end
  end

  assign memReqValid = (state == ST_REQ);
  assign memRspReady = (state == ST_WAIT);
  assign wbValid     = (state == ST_WB);
  assign inFlight    = (state == ST_WAIT) || (state == ST_WB);
  assign loadStall   = (state != ST_IDLE);
endmodule

// File: rtl/sbl_top.sv
module sbl_top
  import sbl_pkg::*;
#(
  parameter int SP_ALIGN_LOG2 = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        featEnable,
  input  logic        spAlignCheck,
  input  logic        instValid,
  output logic        instReady,
  input  logic [31:0] instWord,
  output logic [4:0]  baseIdx,
  input  logic [63:0] baseVal,
  input  logic [63:0] spVal,
  output logic        memReqValid,
  input  logic        memReqReady,
  output logic [63:0] memReqAddr,
  output logic        memReqTagChk,
  input  logic        memRspValid,
  output logic        memRspReady,
  input  logic [7:0]  memRspData,
  output logic        wbValid,
  output logic [4:0]  wbIdx,
  output logic [63:0] wbData,
  output logic        inFlight,
  output logic        loadStall,
  output logic        notThisInst,
  output logic        undefInst,
  output logic        spAlignFault
);
  sbl_strobe_t strobe;
  sbl_decode_t dec;

  sbl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .featEnable(featEnable),
    .dec(dec), .memReqReady(memReqReady), .memRspValid(memRspValid),
    .strobe(strobe), .instReady(instReady), .memReqValid(memReqValid),
    .memRspReady(memRspReady), .wbValid(wbValid), .inFlight(inFlight),
    .loadStall(loadStall), .notThisInst(notThisInst), .undefInst(undefInst),
    .spAlignFault(spAlignFault)
  );

  sbl_datapath #(.SP_ALIGN_LOG2(SP_ALIGN_LOG2)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .instWord(instWord),
    .baseVal(baseVal), .spVal(spVal), .spAlignCheck(spAlignCheck),
    .memRspData(memRspData), .dec(dec), .baseIdx(baseIdx),
    .memReqAddr(memReqAddr), .memReqTagChk(memReqTagChk),
    .wbIdx(wbIdx), .wbData(wbData)
  );
endmodule

// File: rtl/sbl_checker.sv
module sbl_checker (
  input logic        clk,
  input logic        rstN,
  input logic        memReqValid,
  input logic        memReqReady,
  input logic [63:0] memReqAddr,
  input logic        memReqTagChk,
  input logic        memRspValid,
  input logic        memRspReady,
  input logic        wbValid,
  input logic        inFlight,
  input logic        loadStall,
  input logic        instReady,
  input logic        notThisInst,
  input logic        undefInst,
  input logic        spAlignFault
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr) && $stable(memReqTagChk)); // R6
  AST_NOTTHIS_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    notThisInst |-> !memReqValid && !wbValid); // R1
  AST_UNDEF_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    undefInst |-> !memReqValid && !wbValid); // R2
  AST_FAULT_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    spAlignFault |-> !memReqValid && !wbValid); // R5
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({notThisInst, undefInst, spAlignFault})); // R2
  AST_WB_AFTER_RSP: assert property (@(posedge clk) disable iff (!rstN)
    memRspValid && memRspReady |=> wbValid); // R10
  AST_WB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |=> !wbValid); // R10
  AST_WB_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> inFlight && loadStall); // R9
  AST_STALL_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    loadStall |-> !instReady); // R9
  AST_REQ_DONE_INFLIGHT: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqReady |=> inFlight && !memReqValid); // R9
endmodule

bind sbl_top sbl_checker u_chk (
  .clk(clk), .rstN(rstN), .memReqValid(memReqValid), .memReqReady(memReqReady),
  .memReqAddr(memReqAddr), .memReqTagChk(memReqTagChk), .memRspValid(memRspValid),
  .memRspReady(memRspReady), .wbValid(wbValid), .inFlight(inFlight),
  .loadStall(loadStall), .instReady(instReady), .notThisInst(notThisInst),
  .undefInst(undefInst), .spAlignFault(spAlignFault)
);

// File: tb/sbl_top_bench.sv
module sbl_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        featEnable = 1'b1;
  logic        spAlignCheck = 1'b1;
  logic        instValid = 1'b0;
  logic        instReady;
  logic [31:0] instWord = '0;
  logic [4:0]  baseIdx;
  logic [63:0] baseVal = '0;
  logic [63:0] spVal = '0;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [63:0] memReqAddr;
  logic        memReqTagChk;
  logic        memRspValid = 1'b0;
  logic        memRspReady;
  logic [7:0]  memRspData = '0;
  logic        wbValid;
  logic [4:0]  wbIdx;
  logic [63:0] wbData;
  logic        inFlight, loadStall, notThisInst, undefInst, spAlignFault;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sbl_top u_sbl_top (
    .clk(clk), .rstN(rstN), .featEnable(featEnable), .spAlignCheck(spAlignCheck),
    .instValid(instValid), .instReady(instReady), .instWord(instWord),
    .baseIdx(baseIdx), .baseVal(baseVal), .spVal(spVal),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memReqTagChk(memReqTagChk), .memRspValid(memRspValid), .memRspReady(memRspReady),
    .memRspData(memRspData), .wbValid(wbValid), .wbIdx(wbIdx), .wbData(wbData),
    .inFlight(inFlight), .loadStall(loadStall), .notThisInst(notThisInst),
    .undefInst(undefInst), .spAlignFault(spAlignFault)
  );

  function automatic logic [31:0] enc(logic [1:0] opc, logic [8:0] imm, logic [4:0] rn, logic [4:0] rt);
    return {8'h19, opc, 1'b0, imm, 2'b00, rn, rt};
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic doLoad(string req, logic [31:0] word, logic [63:0] base, logic [63:0] sp,
                        bit chkEn, int hold, logic [7:0] rsp, logic [63:0] expAddr,
                        bit expTag, logic [63:0] expData);
    @(negedge clk);
    instValid = 1'b1; instWord = word; baseVal = base; spVal = sp; spAlignCheck = chkEn;
    chk("R4", "baseIdx", 64'(baseIdx), 64'(word[9:5]));
    @(negedge clk);
    instValid = 1'b0; baseVal = ~base; spVal = ~sp;
    chk("R6", "req valid", 64'(memReqValid), 64'd1);
    chk("R3", "req addr", memReqAddr, expAddr);
    chk("R4", "tag check", 64'(memReqTagChk), 64'(expTag));
    chk("R9", "stall early", 64'({loadStall, instReady, inFlight}), 64'b100);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R6", "req held", 64'(memReqValid), 64'd1);
      chk("R6", "addr held", memReqAddr, expAddr);
    end
    memReqReady = 1'b1;
    @(negedge clk);
    memReqReady = 1'b0;
    chk("R9", "in flight", 64'({memReqValid, inFlight, memRspReady, loadStall}), 64'b0111);
    memRspValid = 1'b1; memRspData = rsp;
    @(negedge clk);
    memRspValid = 1'b0; memRspData = ~rsp;
    chk("R10", "wb strobe", 64'(wbValid), 64'd1);
    chk(req, "wb data", wbData, expData);
    chk("R7", "wb index", 64'(wbIdx), 64'(word[4:0]));
    chk("R9", "in flight at wb", 64'(inFlight), 64'd1);
    @(negedge clk);
    chk("R10", "wb single cycle", 64'(wbValid), 64'd0);
    chk("R9", "released", 64'({loadStall, inFlight, instReady}), 64'b001);
  endtask

  task automatic doReject(string req, logic [31:0] word, bit feat, logic [63:0] sp,
                          bit chkEn, logic [2:0] expFlags);
    @(negedge clk);
    featEnable = feat; instValid = 1'b1; instWord = word; spVal = sp; spAlignCheck = chkEn;
    @(negedge clk);
    instValid = 1'b0;
    chk(req, "flags nt/ud/flt", 64'({notThisInst, undefInst, spAlignFault}), 64'(expFlags));
    chk(req, "no request", 64'({memReqValid, loadStall}), 64'd0);
    @(negedge clk);
    chk(req, "flags cleared", 64'({notThisInst, undefInst, spAlignFault}), 64'd0);
    chk(req, "still no request", 64'({memReqValid, wbValid, instReady}), 64'b001);
    featEnable = 1'b1;
  endtask

  task automatic t_reset;
    chk("R11", "reset outputs",
        64'({instReady, memReqValid, memRspReady, wbValid, inFlight, loadStall,
             notThisInst, undefInst, spAlignFault}), 64'b1_0000_0000);
  endtask

  task automatic t_load64;
    doLoad("R7", enc(2'b10, 9'd5, 5'd3, 5'd7), 64'h1000, 64'h0, 1, 2, 8'h80,
           64'h1005, 1, 64'hFFFF_FFFF_FFFF_FF80);
    doLoad("R7", enc(2'b10, 9'h100, 5'd4, 5'd30), 64'h2000, 64'h0, 1, 0, 8'h7F,
           64'h1F00, 1, 64'h0000_0000_0000_007F);
  endtask

  task automatic t_load32;
    doLoad("R8", enc(2'b11, 9'h0FF, 5'd0, 5'd1), 64'h3000, 64'h0, 1, 1, 8'h9C,
           64'h30FF, 1, 64'h0000_0000_FFFF_FF9C);
    doLoad("R8", enc(2'b11, 9'd0, 5'd9, 5'd2), 64'hFFFF_FFFF_0000_0010, 64'h0, 1, 0, 8'h41,
           64'hFFFF_FFFF_0000_0010, 1, 64'h0000_0000_0000_0041);
  endtask

  task automatic t_spBase;
    doLoad("R4", enc(2'b10, 9'h1F0, 5'd31, 5'd5), 64'hDEAD, 64'h8000, 1, 0, 8'h01,
           64'h7FF0, 0, 64'h1);
    doLoad("R5", enc(2'b11, 9'd1, 5'd31, 5'd6), 64'hDEAD, 64'h8008, 0, 0, 8'hF0,
           64'h8009, 0, 64'h0000_0000_FFFF_FFF0);
  endtask

  task automatic t_spFault;
    doReject("R5", enc(2'b10, 9'd0, 5'd31, 5'd5), 1, 64'h8008, 1, 3'b001);
  endtask

  task automatic t_notThis;
    doReject("R1", enc(2'b10, 9'd0, 5'd1, 5'd1) | 32'h0020_0000, 1, 64'h0, 1, 3'b100);
    doReject("R1", enc(2'b01, 9'd0, 5'd1, 5'd1), 1, 64'h0, 1, 3'b100);
    doReject("R1", enc(2'b11, 9'd0, 5'd1, 5'd1) | 32'h0000_0400, 1, 64'h0, 1, 3'b100);
    doReject("R1", enc(2'b10, 9'd0, 5'd1, 5'd1) | 32'h4000_0000, 1, 64'h0, 1, 3'b100);
  endtask

  task automatic t_undef;
    doReject("R2", enc(2'b10, 9'd0, 5'd2, 5'd1), 0, 64'h0, 1, 3'b010);
    doReject("R2", enc(2'b11, 9'd0, 5'd31, 5'd1), 0, 64'h8004, 1, 3'b010);
  endtask

  task automatic t_dit;
    doLoad("R10", enc(2'b10, 9'd2, 5'd8, 5'd9), 64'h500, 64'h0, 1, 0, 8'h00,
           64'h502, 1, 64'h0);
    doLoad("R10", enc(2'b10, 9'd2, 5'd8, 5'd9), 64'h500, 64'h0, 1, 0, 8'hFF,
           64'h502, 1, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_load64();
    t_load32();
    t_spBase();
    t_spFault();
    t_notThis();
    t_undef();
    t_dit();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule